// File: doc/BRIEF.md
# SPI Message Sequencer with Write Prefix

This block is an SPI master that runs one complete message for each command. Software fills a transmit buffer and programs a message word with a byte count and a transfer type. It then writes a command word with a start opcode, a prefix length and a target device number. The block lowers the selected chip select, shifts the bytes out MSB first in 8-bit words, and stores the received bytes in a receive buffer. It then raises chip select and sets a completion flag, which can drive an interrupt line through a mask.

A prefix of up to 15 bytes can be placed before the main phase of a message. Prefix bytes are always transmitted and are never stored on receive. The bytes of the main phase follow the message type, so a read can follow a command header under a single chip-select assertion. The receive buffer is filled from entry 0 with the first byte clocked in after the prefix. Clock polarity, clock phase and one of seven serial clock rates are set in a configuration register. These settings are captured when a message starts.

The register port and the two buffer ports are memory-style. A write is accepted on every cycle it is presented, and reads are combinational, so there is no back-pressure at the block's edge. The register map is: 0 = message word (count in bits [CNT_W-1:0], type in bits [15:14]); 1 = command; 2 = configuration (rate code in [2:0], CPHA in bit 4, CPOL in bit 5); 3 = status (bit 0 done, bit 1 busy); 4 = interrupt mask (bit 0).

Top module: `spi_msg_seq`

## Requirements
- R1: During and right after reset, all chip selects are high, SCLK is 0, MOSI is 0, IRQ is 0 and the status word reads 0.
- R2: A command write with opcode 4'h1 in bits [3:0], issued while idle, lowers only cs_n[device], where the device number is in bits starting at 8. It holds that chip select low for the whole message, produces exactly 16 SCLK edges per byte, and raises it once at the end.
- R3: Status bit 1 (busy) is high from the cycle after a starting command write until completion. A command written while busy is ignored and asserts no chip select.
- R4: Byte i of a message is sent MSB first from transmit buffer entry i when type bit 0 is set (type 2'b01 write, 2'b11 full duplex). Otherwise MOSI is held low for that byte (type 2'b10 read, 2'b00 clock only).
- R5: When type bit 1 is set, each byte received in the main phase is stored in the receive buffer. When type bit 1 is clear, the receive buffer is left unchanged.
- R6: With a prefix length P (command bits [7:4]), bytes 0..P-1 are sent from the transmit buffer whatever the type, and none of them is stored. Received byte i >= P goes to receive entry i-P.
- R7: Rate code c in 0..6 gives an SCLK half period of 2^c system clocks, also from chip-select fall to the first edge. Codes 7 and 6 behave the same.
- R8: SCLK idles at CPOL. With CPHA=0, MISO is sampled on the leading edge and MOSI changes on the trailing edge. With CPHA=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R9: On completion, status bit 0 (done) is set. Writing a status word with bit 0 set clears it. IRQ equals done AND mask bit 0.
- R10: A starting command with a byte count of 0 sets done at once, never raises busy and asserts no chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 16 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 16 | Register read data (combinational) |
| txb_we | input | 1 | Transmit buffer write strobe |
| txb_waddr | input | log2(DEPTH) | Transmit buffer write address |
| txb_wdata | input | 8 | Transmit buffer write data |
| rxb_raddr | input | log2(DEPTH) | Receive buffer read address |
| rxb_rdata | output | 8 | Receive buffer read data (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the devices |
| miso | input | 1 | Serial data from the devices |
| cs_n | output | NCS | Active-low chip selects |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with DEPTH=8 and NCS=2. This keeps messages short enough to sweep every combination of CPOL, CPHA, message type and rate codes 0 and 1, both with and without a 3-byte prefix, including a prefix longer than the message. With a small depth, a prefix as long as the whole buffer followed by a full-buffer read can also be run cheaply. The two devices show whether a command issued while busy reaches the wrong chip select. A separate pass over rate codes 2 to 7 measures every SCLK half period against 2^c clocks.

// File: rtl/spi_msg_pkg.sv
package spi_msg_pkg;
  localparam int REG_W = 16;

  localparam logic [2:0] A_MSG = 3'd0;
  localparam logic [2:0] A_CMD = 3'd1;
  localparam logic [2:0] A_CFG = 3'd2;
  localparam logic [2:0] A_STS = 3'd3;
  localparam logic [2:0] A_MSK = 3'd4;

  localparam logic [3:0] OP_START = 4'h1;
  localparam int         MAX_CODE = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LAST  = 2'd2
  } eng_st_t;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic [2:0] rate;
  } clk_cfg_t;
endpackage

// File: rtl/spi_msg_buf.sv
module spi_msg_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spi_msg_clkdiv.sv
module spi_msg_clkdiv
  import spi_msg_pkg::*;
#(
  localparam int CW = MAX_CODE + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] rate,
  output logic       tick
);
  logic [CW-1:0] cnt_q;
  logic [2:0]    code;
  logic [CW-1:0] lim;

  assign code = (rate > 3'(MAX_CODE)) ? 3'(MAX_CODE) : rate;
  assign lim  = (CW'(1) << code) - CW'(1);
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/spi_msg_regs.sv
module spi_msg_regs
  import spi_msg_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int DEV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_waddr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [2:0]       reg_raddr,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             busy,
  input  logic             fin,
  output logic             start,
  output logic [CNT_W-1:0] s_cnt,
  output logic [1:0]       s_typ,
  output logic [3:0]       s_pre,
  output logic [DEV_W-1:0] s_dev,
  output clk_cfg_t         cfg,
  output logic             done,
  output logic             irq
);
  logic [REG_W-1:0] msg_q;
  clk_cfg_t         cfg_q;
  logic             done_q;
  logic             mask_q;

  assign start = reg_we && (reg_waddr == A_CMD) && (reg_wdata[3:0] == OP_START) && !busy;
  assign s_pre = reg_wdata[7:4];
  assign s_dev = reg_wdata[8 +: DEV_W];
  assign s_cnt = msg_q[CNT_W-1:0];
  assign s_typ = msg_q[15:14];
  assign cfg   = cfg_q;
  assign done  = done_q;
  assign irq   = done_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_q  <= '0;
      cfg_q  <= '0;
      done_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (reg_we && reg_waddr == A_MSG) msg_q <= reg_wdata;
      if (reg_we && reg_waddr == A_CFG) cfg_q <= '{cpol: reg_wdata[5], cpha: reg_wdata[4], rate: reg_wdata[2:0]};
      if (reg_we && reg_waddr == A_MSK) mask_q <= reg_wdata[0];
      if (fin) done_q <= 1'b1;
      else if (reg_we && reg_waddr == A_STS && reg_wdata[0]) done_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_raddr)
      A_MSG:   reg_rdata = msg_q;
      A_CFG:   reg_rdata = REG_W'({cfg_q.cpol, cfg_q.cpha, 1'b0, cfg_q.rate});
      A_STS:   reg_rdata = REG_W'({busy, done_q});
      A_MSK:   reg_rdata = REG_W'(mask_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_msg_engine.sv
module spi_msg_engine
  import spi_msg_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int AW    = 4,
  parameter int DEV_W = 2,
  parameter int NCS   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] s_cnt,
  input  logic [1:0]       s_typ,
  input  logic [3:0]       s_pre,
  input  logic [DEV_W-1:0] s_dev,
  input  clk_cfg_t         cfg,
  input  logic             tick,
  output logic             run,
  output logic [2:0]       rate,
  output logic [AW-1:0]    tx_addr,
  input  logic [7:0]       tx_rdata,
  output logic             rx_we,
  output logic [AW-1:0]    rx_addr,
  output logic [7:0]       rx_wdata,
  output logic             busy,
  output logic             fin,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic [NCS-1:0]   cs_n
);
  eng_st_t          st_q;
  logic [CNT_W-1:0] cnt_q, idx_q, nxt;
  logic [1:0]       typ_q;
  logic [3:0]       pre_q;
  clk_cfg_t         cfg_q;
  logic [3:0]       ecnt_q;
  logic             phase_q, mosi_q;
  logic [7:0]       sh_q, rx_sh_q;
  logic [NCS-1:0]   cs_q, cs_sel;
  logic [7:0]       b0, nb;
  logic             byte_end, last;

  assign nxt      = idx_q + CNT_W'(1);
  assign last     = (idx_q == cnt_q - CNT_W'(1));
  assign busy     = (st_q != ST_IDLE);
  assign run      = busy;
  assign rate     = cfg_q.rate;
  assign tx_addr  = busy ? AW'(nxt) : '0;
  assign b0       = (s_typ[0] || s_pre != 4'd0) ? tx_rdata : 8'h00;
  assign nb       = (typ_q[0] || nxt < CNT_W'(pre_q)) ? tx_rdata : 8'h00;
  assign byte_end = (st_q == ST_SHIFT) && tick && (ecnt_q == 4'd15);
  assign rx_wdata = cfg_q.cpha ? {rx_sh_q[6:0], miso} : rx_sh_q;
  assign rx_we    = byte_end && typ_q[1] && (idx_q >= CNT_W'(pre_q));
  assign rx_addr  = AW'(idx_q - CNT_W'(pre_q));
  assign fin      = ((st_q == ST_LAST) && tick) || (start && s_cnt == '0);
  assign sclk     = phase_q ^ (busy ? cfg_q.cpol : cfg.cpol);
  assign mosi     = mosi_q;
  assign cs_n     = cs_q;

  always_comb begin
    for (int d = 0; d < NCS; d++) cs_sel[d] = !(DEV_W'(d) == s_dev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; idx_q <= '0; typ_q <= '0; pre_q <= '0;
      cfg_q <= '0; ecnt_q <= '0; phase_q <= 1'b0; mosi_q <= 1'b0;
      sh_q <= '0; rx_sh_q <= '0; cs_q <= '1;
    end else begin
      case (st_q)
        ST_IDLE: if (start && s_cnt != '0) begin
          st_q <= ST_SHIFT; cnt_q <= s_cnt; typ_q <= s_typ; pre_q <= s_pre;
          cfg_q <= cfg; idx_q <= '0; ecnt_q <= '0; phase_q <= 1'b0; cs_q <= cs_sel;
          if (!cfg.cpha) begin mosi_q <= b0[7]; sh_q <= {b0[6:0], 1'b0}; end
          else begin mosi_q <= 1'b0; sh_q <= b0; end
        end
        ST_SHIFT: if (tick) begin
          phase_q <= ~phase_q;
          ecnt_q  <= ecnt_q + 4'd1;
          if (!ecnt_q[0]) begin
            if (!cfg_q.cpha) rx_sh_q <= {rx_sh_q[6:0], miso};
            else begin mosi_q <= sh_q[7]; sh_q <= {sh_q[6:0], 1'b0}; end
          end else begin
            if (cfg_q.cpha) rx_sh_q <= {rx_sh_q[6:0], miso};
            else if (ecnt_q != 4'd15) begin mosi_q <= sh_q[7]; sh_q <= {sh_q[6:0], 1'b0}; end
            if (ecnt_q == 4'd15) begin
              if (last) st_q <= ST_LAST;
              else begin
                idx_q <= nxt;
                if (!cfg_q.cpha) begin mosi_q <= nb[7]; sh_q <= {nb[6:0], 1'b0}; end
                else sh_q <= nb;
              end
            end
          end
        end
        ST_LAST: if (tick) begin
          st_q <= ST_IDLE; cs_q <= '1; mosi_q <= 1'b0; phase_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_msg_seq.sv
module spi_msg_seq
  import spi_msg_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NCS   = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 16),
  localparam int DEV_W = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [2:0]     reg_waddr,
  input  logic [15:0]    reg_wdata,
  input  logic [2:0]     reg_raddr,
  output logic [15:0]    reg_rdata,
  input  logic           txb_we,
  input  logic [AW-1:0]  txb_waddr,
  input  logic [7:0]     txb_wdata,
  input  logic [AW-1:0]  rxb_raddr,
  output logic [7:0]     rxb_rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n,
  output logic           irq
);
  logic             start_w, busy_w, fin_w, done_w, tick_w, run_w;
  logic [CNT_W-1:0] s_cnt_w;
  logic [1:0]       s_typ_w;
  logic [3:0]       s_pre_w;
  logic [DEV_W-1:0] s_dev_w;
  clk_cfg_t         cfg_w;
  logic [2:0]       rate_w;
  logic [AW-1:0]    tx_addr_w, rx_addr_w;
  logic [7:0]       tx_rdata_w, rx_wdata_w;
  logic             rx_we_w;

  spi_msg_regs #(.CNT_W(CNT_W), .DEV_W(DEV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .busy(busy_w), .fin(fin_w), .start(start_w), .s_cnt(s_cnt_w),
    .s_typ(s_typ_w), .s_pre(s_pre_w), .s_dev(s_dev_w), .cfg(cfg_w),
    .done(done_w), .irq(irq)
  );

  spi_msg_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .run(run_w), .rate(rate_w), .tick(tick_w)
  );

  spi_msg_engine #(.CNT_W(CNT_W), .AW(AW), .DEV_W(DEV_W), .NCS(NCS)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_w), .s_cnt(s_cnt_w), .s_typ(s_typ_w),
    .s_pre(s_pre_w), .s_dev(s_dev_w), .cfg(cfg_w), .tick(tick_w), .run(run_w),
    .rate(rate_w), .tx_addr(tx_addr_w), .tx_rdata(tx_rdata_w), .rx_we(rx_we_w),
    .rx_addr(rx_addr_w), .rx_wdata(rx_wdata_w), .busy(busy_w), .fin(fin_w),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  spi_msg_buf #(.DEPTH(DEPTH), .DW(8)) u_txb (
    .clk(clk), .we(txb_we), .waddr(txb_waddr), .wdata(txb_wdata),
    .raddr(tx_addr_w), .rdata(tx_rdata_w)
  );

  spi_msg_buf #(.DEPTH(DEPTH), .DW(8)) u_rxb (
    .clk(clk), .we(rx_we_w), .waddr(rx_addr_w), .wdata(rx_wdata_w),
    .raddr(rxb_raddr), .rdata(rxb_rdata)
  );
endmodule

// File: rtl/spi_msg_seq_chk.sv
module spi_msg_seq_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic [NCS-1:0] cs_n,
  input logic           sclk,
  input logic           mosi,
  input logic           cpol_live,
  input logic           rx_we
);
  p_one_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  p_idle_cs_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n));

  p_cs_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_n));

  p_mosi_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);

  p_rx_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> busy);

  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol_live));

  p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind spi_msg_seq spi_msg_seq_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .done(done_w), .cs_n(cs_n),
  .sclk(sclk), .mosi(mosi), .cpol_live(cfg_w.cpol), .rx_we(rx_we_w)
);

// File: tb/spi_msg_seq_tb.sv
module spi_msg_seq_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;
  localparam int NCS   = 2;
  localparam int AW    = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0; logic [2:0] reg_waddr = '0, reg_raddr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic txb_we = 1'b0; logic [AW-1:0] txb_waddr = '0, rxb_raddr = '0;
  logic [7:0] txb_wdata = '0, rxb_rdata;
  logic sclk, mosi, miso = 1'b0, irq;
  logic [NCS-1:0] cs_n;

  always #(CLK_P/2) clk = ~clk;

  spi_msg_seq #(.DEPTH(DEPTH), .NCS(NCS)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .txb_we(txb_we), .txb_waddr(txb_waddr), .txb_wdata(txb_wdata),
    .rxb_raddr(rxb_raddr), .rxb_rdata(rxb_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] txv(input int i);
    return 8'(8'h91 + i * 23);
  endfunction
  function automatic logic [7:0] rsp(input int k);
    return 8'(8'h3C ^ (k * 29 + 7));
  endfunction
  function automatic logic bitof(input int o);
    logic [7:0] b;
    b = rsp(o / 8);
    return b[7 - (o % 8)];
  endfunction

  // ---------------- device model ----------------
  logic cpol_b = 1'b0, cpha_b = 1'b0;
  int   hp_exp = CLK_P;
  int   cs_falls [NCS];
  int   cs_rises = 0, nedges = 0, hp_err = 0, ob = 0, ib = 0;
  logic [7:0] ish = '0;
  logic [7:0] cap [32];
  logic [NCS-1:0] cs_prev = '1;
  time  t_ref = 0;

  initial for (int d = 0; d < NCS; d++) cs_falls[d] = 0;

  always @(cs_n) begin
    for (int d = 0; d < NCS; d++) if (cs_prev[d] === 1'b1 && cs_n[d] === 1'b0) cs_falls[d]++;
    if ((&cs_prev) && !(&cs_n)) begin
      ob = 0; ib = 0; t_ref = $time;
      miso = cpha_b ? 1'b0 : bitof(0);
    end
    if (!(&cs_prev) && (&cs_n)) cs_rises++;
    cs_prev = cs_n;
  end

  always @(sclk) begin
    if (!(&cs_n) && rst_n) begin
      if (($time - t_ref) != time'(hp_exp)) hp_err++;
      t_ref = $time;
      nedges++;
      if ((sclk != cpol_b) == !cpha_b) begin
        ish = {ish[6:0], mosi};
        ib++;
        if (ib % 8 == 0 && ib / 8 <= 32) cap[ib / 8 - 1] = ish;
      end else if (!cpha_b) begin
        ob++; miso = bitof(ob);
      end else begin
        miso = bitof(ob); ob++;
      end
    end
  end

  // ---------------- host access ----------------
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic txw(input int a, input logic [7:0] d);
    @(negedge clk); txb_we = 1'b1; txb_waddr = AW'(a); txb_wdata = d;
    @(negedge clk); txb_we = 1'b0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_raddr = a; #1; d = reg_rdata;
  endtask

  logic [7:0] rx_model [DEPTH];

  task automatic run_msg(input logic cpol, input logic cpha, input int code,
                         input logic [1:0] typ, input int n, input int p,
                         input int dev, input logic mask, input bit interfere);
    logic [15:0] v;
    int f0 [NCS];
    int c;
    cpol_b = cpol; cpha_b = cpha;
    c = (code > 6) ? 6 : code;
    hp_exp = CLK_P * (1 << c);
    wr(3'd2, 16'({cpol, cpha, 1'b0, 3'(code)}));
    wr(3'd4, 16'(mask));
    for (int i = 0; i < DEPTH; i++) txw(i, txv(i));
    wr(3'd0, 16'({typ, 14'(n)}));
    for (int d = 0; d < NCS; d++) f0[d] = cs_falls[d];
    cs_rises = 0; nedges = 0; hp_err = 0;
    for (int i = 0; i < 32; i++) cap[i] = 'x;
    wr(3'd1, 16'((dev << 8) | (p << 4) | 1));
    rd(3'd3, v);
    chk(v[1] == 1'b1, "R3 busy after command", int'(v[1]), 1);
    if (interfere) wr(3'd1, 16'((((dev + 1) % NCS) << 8) | 1));
    do begin @(negedge clk); rd(3'd3, v); end while (v[1]);
    for (int d = 0; d < NCS; d++)
      chk(cs_falls[d] - f0[d] == ((d == dev) ? 1 : 0),
          interfere ? "R3 command while busy ignored" : "R2 chip select choice",
          cs_falls[d] - f0[d], (d == dev) ? 1 : 0);
    chk(cs_rises == 1, "R2 single release", cs_rises, 1);
    chk(nedges == 16 * n, "R2 edge count", nedges, 16 * n);
    chk(hp_err == 0, "R7 half period", hp_err, 0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = (typ[0] || i < p) ? txv(i % DEPTH) : 8'h00;
      chk(cap[i] === e, (i < p) ? "R6 prefix byte sent" : "R4 MOSI byte", int'(cap[i]), int'(e));
    end
    for (int i = 0; i < n; i++) if (typ[1] && i >= p) rx_model[(i - p) % DEPTH] = rsp(i);
    for (int i = 0; i < DEPTH; i++) begin
      rxb_raddr = AW'(i); #1;
      chk(rxb_rdata === rx_model[i], (p > 0) ? "R6 receive offset" : "R5 receive store",
          int'(rxb_rdata), int'(rx_model[i]));
    end
    rd(3'd3, v);
    chk(v[0] == 1'b1, "R9 done set", int'(v[0]), 1);
    chk(irq == mask, "R9 irq follows mask", int'(irq), int'(mask));
    wr(3'd3, 16'hFFFF);
    rd(3'd3, v);
    chk(v[0] == 1'b0 && irq == 1'b0, "R9 done cleared", int'({irq, v[0]}), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rd(3'd3, v);
    chk(&cs_n && sclk == 1'b0 && mosi == 1'b0 && irq == 1'b0 && v == 16'h0,
        "R1 reset state", int'({cs_n, sclk, mosi, irq, v[1:0]}), int'({2'b11, 5'b0}));
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd3, v);
    chk(&cs_n && sclk == 1'b0 && irq == 1'b0 && v == 16'h0, "R1 after reset",
        int'({cs_n, sclk, irq, v[1:0]}), int'({2'b11, 4'b0}));

    // fill the receive buffer with a known pattern via a full-duplex read
    for (int i = 0; i < DEPTH; i++) rx_model[i] = rsp(i);
    run_msg(1'b0, 1'b0, 0, 2'b11, DEPTH, 0, 0, 1'b0, 0);

    // sweep of modes, types, prefix and fast rates
    for (int pol = 0; pol < 2; pol++)
      for (int pha = 0; pha < 2; pha++)
        for (int t = 0; t < 4; t++)
          for (int pp = 0; pp < 2; pp++)
            for (int cd = 0; cd < 2; cd++) begin
              int n;
              n = 2 + (t + cd + pol) % 4;
              run_msg(1'(pol), 1'(pha), cd, 2'(t), n, pp * 3, (pha + t) % NCS, 1'(n), 0);
            end

    // slower rates, including the code beyond the slowest (R7)
    for (int cd = 2; cd < 8; cd++) run_msg(1'(cd), 1'(cd >> 1), cd, 2'b11, 1, 0, cd % NCS, 1'b1, 0);

    // prefix as long as the buffer followed by a full-buffer read (R6)
    run_msg(1'b1, 1'b1, 0, 2'b10, 2 * DEPTH, DEPTH, 1, 1'b0, 0);

    // command written while busy (R3)
    run_msg(1'b0, 1'b1, 2, 2'b11, 3, 0, 0, 1'b1, 1);

    // zero-length message (R10)
    begin
      int f0, f1;
      f0 = cs_falls[0]; f1 = cs_falls[1];
      wr(3'd0, 16'({2'b11, 14'd0}));
      wr(3'd1, 16'h0001);
      rd(3'd3, v);
      chk(v[1:0] == 2'b01, "R10 zero count done without busy", int'(v[1:0]), 1);
      chk(cs_falls[0] == f0 && cs_falls[1] == f1, "R10 no chip select",
          cs_falls[0] + cs_falls[1], f0 + f1);
      wr(3'd3, 16'h0001);
    end

    finish_run();
  end
endmodule